// File: doc/BRIEF.md
# Selectable Output Clock Path

This block produces four output clocks, labelled channels A, B, C and D. Each channel picks one of four sources and passes it through a post-divider of its own. The four sources are the reference clock and three PLL clocks. The PLLs themselves live outside the block. Every source is presented as a one-cycle tick on the fast system clock, one tick per source period. An output clock is the tick stream the post-divider emits.

Channels C and D each hold two complete source/divider settings. A level on `sel_alt_i` picks between them, so the rate can change without rewriting any configuration. A power-down mask says which PLLs and post-dividers may be shut down. The `pd_i` pin applies that mask. The `oe_i` pin enables or releases all four output drivers.

The block also reports when every PLL and every post-divider is powered down, because in that state the reference oscillator would be stopped. All outputs are registered, and each one follows its inputs by exactly one clock.

Top module: `clkpath_top`

## Requirements
- R1: Each channel's 2-bit source code picks its source: 0 is the reference (`src_tick_i[0]`), and 1, 2 and 3 are PLL A, B and C (`src_tick_i[1..3]`). An output tick only ever follows a source tick.
- R2: A divider code k of 1 or more gives one output tick for every k ticks of the selected source. A code of 0 means divide by one. The tick appears on `clk_o` one cycle after the source tick that reaches terminal count, and the counter then reloads.
- R3: The configuration slots are numbered 0 to 5 (A, B, C-set1, D-set1, C-set2, D-set2). Slot i uses `cfg_src_i[2i+1:2i]` and `cfg_div_i[DIV_W*i +: DIV_W]`. With `sel_alt_i` low, channels C and D use slots 2 and 3; with it high, they use slots 4 and 5. Channels A and B always use slots 0 and 1.
- R4: When `pd_i` is high and mask bit `pd_mask_i[j]` is set for PLL j (j = 0, 1, 2 for A, B, C), that PLL's ticks are treated as absent by every channel.
- R5: When `pd_i` is high and `pd_mask_i[3+k]` is set, channel k's output is low on the next cycle and its counter is cleared.
- R6: `drive_o` is all ones the cycle after `oe_i` is high, and all zeros the cycle after `oe_i` is low (outputs released).
- R7: `osc_off_o` is high the cycle after `pd_i` is high with all seven mask bits set, and low otherwise.
- R8: With every source and divider code zero and nothing powered down, every `clk_o` bit repeats `src_tick_i[0]` one cycle later.
- R9: While `rst_n` is low, `clk_o`, `drive_o` and `osc_off_o` are all zero and every counter is zero.
- R10: If the divider code drops below a channel's current count, the next selected tick is treated as terminal count. The channel outputs a tick and restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 4 | Source ticks: bit 0 reference, bits 1..3 PLL A..C |
| cfg_src_i | input | 12 | Six 2-bit source codes, slot i at bits 2i+1:2i |
| cfg_div_i | input | 6*DIV_W | Six post-divider codes, slot i at DIV_W*i |
| pd_mask_i | input | 7 | Power-down enables: bits 0..2 PLL A..C, bits 3..6 post-dividers A..D |
| pd_i | input | 1 | Applies the power-down mask when high |
| oe_i | input | 1 | Output enable; low releases all outputs |
| sel_alt_i | input | 1 | Selects the second settings for channels C and D |
| clk_o | output | 4 | Output clock ticks, channels A..D |
| drive_o | output | 4 | Output driver enables, channels A..D |
| osc_off_o | output | 1 | Reference oscillator would be stopped |

## Verification
Every result comes one clock after the inputs that cause it: output ticks, driver enables and the oscillator flag alike, because each passes through a single register. The bench sets inputs just after a falling edge and lets one rising edge register them. It compares at the next falling edge against a model that was stepped with those same inputs. That model holds its own counters, so division, reloading and the shrink-below-count case are checked tick by tick, including across switches of `sel_alt_i`.

// File: rtl/clkpath_pkg.sv
package clkpath_pkg;
    localparam int NUM_CH   = 4;
    localparam int NUM_SRC  = 4;
    localparam int NUM_PLL  = 3;
    localparam int NUM_SLOT = 6;
    localparam int SRC_W    = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_REF  = 2'd0,
        SRC_PLLA = 2'd1,
        SRC_PLLB = 2'd2,
        SRC_PLLC = 2'd3
    } src_sel_e;
endpackage

// File: rtl/clkpath_src_gate.sv
module clkpath_src_gate
    import clkpath_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic [NUM_PLL-1:0] pll_pd_mask_i,
    input  logic               pd_i,
    output logic [NUM_SRC-1:0] eff_tick_o
);
    always_comb begin
        eff_tick_o[0] = src_tick_i[0];
        for (int j = 0; j < NUM_PLL; j++) begin
            eff_tick_o[j+1] = src_tick_i[j+1] & ~(pd_i & pll_pd_mask_i[j]);
        end
    end
endmodule

// File: rtl/clkpath_cfg_pick.sv
module clkpath_cfg_pick
    import clkpath_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic [NUM_SLOT*SRC_W-1:0] cfg_src_i,
    input  logic [NUM_SLOT*DIV_W-1:0] cfg_div_i,
    input  logic                      sel_alt_i,
    output logic [NUM_CH*SRC_W-1:0]   ch_src_o,
    output logic [NUM_CH*DIV_W-1:0]   ch_div_o
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int BASE = k;
        localparam int ALT  = (k >= 2) ? k + 2 : k;
        always_comb begin
            if (sel_alt_i && (k >= 2)) begin
                ch_src_o[k*SRC_W +: SRC_W] = cfg_src_i[ALT*SRC_W +: SRC_W];
                ch_div_o[k*DIV_W +: DIV_W] = cfg_div_i[ALT*DIV_W +: DIV_W];
            end else begin
                ch_src_o[k*SRC_W +: SRC_W] = cfg_src_i[BASE*SRC_W +: SRC_W];
                ch_div_o[k*DIV_W +: DIV_W] = cfg_div_i[BASE*DIV_W +: DIV_W];
            end
        end
    end
endmodule

// File: rtl/clkpath_postdiv.sv
module clkpath_postdiv
    import clkpath_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] eff_tick_i,
    input  logic [SRC_W-1:0]   src_sel_i,
    input  logic [DIV_W-1:0]   div_code_i,
    input  logic               pwr_dn_i,
    output logic               tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } pd_state_t;

    pd_state_t  st_d, st_q;
    logic [DIV_W-1:0] last_cnt;
    logic             picked;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        last_cnt  = (div_code_i == '0) ? '0 : div_code_i - 1'b1;
        picked    = eff_tick_i[src_sel_i];
        if (pwr_dn_i) begin
            st_d.cnt = '0;
        end else if (picked) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/clkpath_top.sv
module clkpath_top
    import clkpath_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                src_tick_i,
    input  logic [11:0]               cfg_src_i,
    input  logic [6*DIV_W-1:0]        cfg_div_i,
    input  logic [6:0]                pd_mask_i,
    input  logic                      pd_i,
    input  logic                      oe_i,
    input  logic                      sel_alt_i,
    output logic [3:0]                clk_o,
    output logic [3:0]                drive_o,
    output logic                      osc_off_o
);
    localparam int MASK_W = NUM_PLL + NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0] drive;
        logic              osc_off;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [NUM_SRC-1:0]      eff_tick;
    logic [NUM_CH*SRC_W-1:0] ch_src;
    logic [NUM_CH*DIV_W-1:0] ch_div;

    clkpath_src_gate u_gate (
        .src_tick_i    (src_tick_i),
        .pll_pd_mask_i (pd_mask_i[NUM_PLL-1:0]),
        .pd_i          (pd_i),
        .eff_tick_o    (eff_tick)
    );

    clkpath_cfg_pick #(.DIV_W(DIV_W)) u_pick (
        .cfg_src_i (cfg_src_i),
        .cfg_div_i (cfg_div_i),
        .sel_alt_i (sel_alt_i),
        .ch_src_o  (ch_src),
        .ch_div_o  (ch_div)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_div
        clkpath_postdiv #(.DIV_W(DIV_W)) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .eff_tick_i (eff_tick),
            .src_sel_i  (ch_src[k*SRC_W +: SRC_W]),
            .div_code_i (ch_div[k*DIV_W +: DIV_W]),
            .pwr_dn_i   (pd_i & pd_mask_i[NUM_PLL+k]),
            .tick_o     (clk_o[k])
        );
    end

    always_comb begin
        st_d.drive   = {NUM_CH{oe_i}};
        st_d.osc_off = pd_i & (&pd_mask_i[MASK_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_o   = st_q.drive;
    assign osc_off_o = st_q.osc_off;
endmodule

// File: rtl/clkpath_chk.sv
module clkpath_chk #(
    parameter int DIV_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         src_tick_i,
    input logic [11:0]        cfg_src_i,
    input logic [6*DIV_W-1:0] cfg_div_i,
    input logic [6:0]         pd_mask_i,
    input logic               pd_i,
    input logic               oe_i,
    input logic [3:0]         clk_o,
    input logic [3:0]         drive_o,
    input logic               osc_off_o
);
    assert_tick_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_o != 4'b0) |-> $past(src_tick_i != 4'b0));

    assert_pd_forces_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((clk_o & $past({4{pd_i}} & pd_mask_i[6:3])) == 4'b0));

    assert_oe_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drive_o == {4{$past(oe_i)}}));

    assert_osc_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (osc_off_o == $past(pd_i & (&pd_mask_i))));

    assert_zero_cfg_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src_i == '0 && cfg_div_i == '0 && !pd_i) |=> (clk_o == {4{$past(src_tick_i[0])}}));
endmodule

bind clkpath_top clkpath_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_tick_i (src_tick_i),
    .cfg_src_i  (cfg_src_i),
    .cfg_div_i  (cfg_div_i),
    .pd_mask_i  (pd_mask_i),
    .pd_i       (pd_i),
    .oe_i       (oe_i),
    .clk_o      (clk_o),
    .drive_o    (drive_o),
    .osc_off_o  (osc_off_o)
);

// File: tb/tb_clkpath_top.sv
`timescale 1ns/1ps
module tb_clkpath_top;
    localparam int DIV_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         src_tick_i = '0;
    logic [11:0]        cfg_src_i = '0;
    logic [6*DIV_W-1:0] cfg_div_i = '0;
    logic [6:0]         pd_mask_i = '0;
    logic               pd_i = 1'b0;
    logic               oe_i = 1'b0;
    logic               sel_alt_i = 1'b0;
    logic [3:0]         clk_o, drive_o;
    logic               osc_off_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [DIV_W-1:0] m_cnt [4];
    logic [3:0] exp_clk, exp_drive;
    logic       exp_osc;

    always #2.5 clk = ~clk;

    clkpath_top #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i), .cfg_src_i(cfg_src_i),
        .cfg_div_i(cfg_div_i), .pd_mask_i(pd_mask_i), .pd_i(pd_i), .oe_i(oe_i),
        .sel_alt_i(sel_alt_i), .clk_o(clk_o), .drive_o(drive_o), .osc_off_o(osc_off_o)
    );

    function automatic int slot_of(int ch, logic alt);
        return (alt && ch >= 2) ? ch + 2 : ch;
    endfunction

    task automatic step_model();
        logic [3:0] eff;
        eff[0] = src_tick_i[0];
        for (int j = 0; j < 3; j++) eff[j+1] = src_tick_i[j+1] & ~(pd_i & pd_mask_i[j]);
        for (int k = 0; k < 4; k++) begin
            int s = slot_of(k, sel_alt_i);
            int code = int'(cfg_div_i[s*DIV_W +: DIV_W]);
            int modv = (code == 0) ? 1 : code;
            int src = int'(cfg_src_i[s*2 +: 2]);
            exp_clk[k] = 1'b0;
            if (pd_i && pd_mask_i[3+k]) m_cnt[k] = '0;
            else if (eff[src]) begin
                if (int'(m_cnt[k]) >= modv - 1) begin
                    m_cnt[k] = '0;
                    exp_clk[k] = 1'b1;
                end else m_cnt[k] = m_cnt[k] + 1'b1;
            end
        end
        exp_drive = {4{oe_i}};
        exp_osc   = pd_i & (&pd_mask_i);
    endtask

    task automatic check_out(string tag);
        checks++;
        if (clk_o !== exp_clk) begin
            errors++;
            $display("FAIL %s clk_o got %b exp %b", tag, clk_o, exp_clk);
        end
        checks++;
        if (drive_o !== exp_drive) begin
            errors++;
            $display("FAIL %s drive_o got %b exp %b", tag, drive_o, exp_drive);
        end
        checks++;
        if (osc_off_o !== exp_osc) begin
            errors++;
            $display("FAIL %s osc_off_o got %b exp %b", tag, osc_off_o, exp_osc);
        end
    endtask

    // mode: 1 zero cfg, 2 fixed sel, 3 sel toggling, 4 power-down, 5 oe, 6 shrink
    task automatic run_phase(string tag, int n, int mode);
        for (int i = 0; i < n; i++) begin
            src_tick_i = 4'($urandom);
            if (mode == 1) begin
                cfg_src_i = '0; cfg_div_i = '0; pd_i = 1'b0; oe_i = 1'b1;
            end else if (mode == 6) begin
                src_tick_i = 4'b0001;
                cfg_src_i = '0;
                cfg_div_i = (i < 12) ? {6{4'd15}} : {6{4'd2}};
                pd_i = 1'b0; oe_i = 1'b1;
            end else begin
                if (i % 16 == 0) begin
                    cfg_src_i = 12'($urandom);
                    cfg_div_i = 24'($urandom) & {6{4'h7}};
                end
                pd_i = 1'b0; oe_i = 1'b1;
                if (mode == 3) sel_alt_i = 1'($urandom);
                if (mode == 4) begin
                    pd_i = 1'($urandom);
                    pd_mask_i = ($urandom % 4 == 0) ? 7'h7f : 7'($urandom);
                end
                if (mode == 5) oe_i = 1'($urandom);
            end
            step_model();
            @(negedge clk);
            check_out(tag);
        end
        pd_i = 1'b0;
        pd_mask_i = '0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 4; k++) m_cnt[k] = '0;
        exp_clk = '0; exp_drive = '0; exp_osc = 1'b0;
        src_tick_i = 4'hf; pd_i = 1'b1; pd_mask_i = 7'h7f; oe_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R9 reset");
        pd_i = 1'b0; pd_mask_i = '0;
        rst_n = 1'b1;
        run_phase("R8 zero config", 200, 1);
        sel_alt_i = 1'b0;
        run_phase("R1 R2 source and divide", 1500, 2);
        sel_alt_i = 1'b1;
        run_phase("R2 divide alt set", 800, 2);
        run_phase("R3 alt select toggling", 1500, 3);
        run_phase("R4 R5 R7 power down", 1500, 4);
        run_phase("R6 output enable", 400, 5);
        run_phase("R10 shrink below count", 40, 6);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule